// File: doc/BRIEF.md
# Reconfigurable Comb and Biquad Filter Section

This block is a streaming filter engine for signed 16-bit real samples. A delay-line differencer sits in front of a second-order recursive section. The differencer can be bypassed, and its delay is 8 or 16 samples. The recursive section has three feedforward taps and two feedback taps. A 4-bit function code picks a fixed coefficient set. With these sets the one datapath acts as a differencer, an integrator, a leaky integrator, a DC blocker, a comb, a bandpass, a comb-integrator interpolator, a moving averager or a recursive sinusoid generator. One further code takes its coefficients and comb settings from input ports instead, for user-designed sections such as equalisers and general IIR filters.

For each accepted input sample the section produces exactly one output sample, two clock edges later. The section computes `y[n] = f0·w[n] + f1·w[n-1] + f2·w[n-2] + g1·y[n-1] + g2·y[n-2]`, where `w` is the differencer output. The sum is kept at full precision, then rounded and saturated to 16 bits. The saturated output is also the value fed back.

Top module: `recon_filter_section`

## Requirements
- R1: Coefficients are 18-bit signed with 16 fraction bits (1.0 = 65536). The output is the full-precision sum, rounded half up at bit 16, then clipped to the range -32768..32767. Function code 0 passes the input through (f0 = 1.0).
- R2: When the differencer is on, w[n] = x[n] − x[n−D]. D is 16 when the long-delay flag is set and 8 otherwise. When it is off, w[n] = x[n].
- R3: Code 1 is a first difference (f0 = 1, f1 = −1). Code 2 is an integrator (f0 = 1, g1 = 1). The differencer is off for both.
- R4: Code 3 is a leaky integrator (f0 = 1, g1 = 0.9375). Code 7 is a DC blocker (f0 = 1, f1 = −1, g1 = 0.9375).
- R5: Code 4 is a comb (f0 = 1, differencer on, D = 8). Code 5 is a bandpass (f0 = 1, g2 = −1, differencer on, D = 16).
- R6: Code 6 is a comb-integrator interpolator (differencer on, D = 8, f0 = 1, g1 = 1). Code 8 is a moving averager (differencer on, D = 8, f0 = 1/8, g1 = 1).
- R7: A sample accepted at a clock edge appears on `out_data` with `out_valid` high after the following edge. The block keeps up with one sample per cycle and gives exactly one output per accepted sample.
- R8: A `flush` pulse, or any cycle in which `fsel` differs from its value in the previous cycle, clears the delay line and all history to zero and cancels samples in flight. A sample offered in that cycle is dropped. `out_data` keeps its last value.
- R9: Code 9 is an oscillator (f0 = 1, g1 = 121095 ≈ 2cos(π/8), g2 = −1). A single impulse at its input starts a self-sustained sinusoid.
- R10: Code 15 uses `prog_*` ports for f0, f1, f2, g1, g2, differencer enable and long delay. Codes 10 to 14 have all coefficients zero, so their output is 0.
- R11: Results beyond the 16-bit range saturate, and the saturated value is what the feedback taps use next.
- R12: While `rst` is high, and after it, `out_valid` is 0 and `out_data` is 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous clear of all filter state |
| fsel | input | 4 | Function code |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| prog_f0 | input | 18 | Programmable feedforward tap 0 |
| prog_f1 | input | 18 | Programmable feedforward tap 1 |
| prog_f2 | input | 18 | Programmable feedforward tap 2 |
| prog_g1 | input | 18 | Programmable feedback tap 1 |
| prog_g2 | input | 18 | Programmable feedback tap 2 |
| prog_diff_on | input | 1 | Programmable differencer enable |
| prog_diff_long | input | 1 | Programmable differencer delay select (1 = 16) |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Output sample, two's complement |

## Verification
A corrupted feedback register shows up on the very next output. It then never goes away in the integrating modes (codes 2, 6, 8) and the oscillator. A bad entry in the differencer delay line stays hidden for 8 or 16 samples, so the tests run at least D+1 samples in the comb modes. A clear that misses a register shows up as history leaking into the first sample after a flush or code change, which the tests look at directly. A latency fault moves `out_valid` by a cycle on the first sample.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int COEF_W    = 18;
  localparam int COEF_FRAC = 16;

  typedef enum logic [3:0] {
    FS_PASS  = 4'd0,
    FS_DIFF  = 4'd1,
    FS_INTEG = 4'd2,
    FS_LEAKY = 4'd3,
    FS_COMB  = 4'd4,
    FS_BAND  = 4'd5,
    FS_CIC   = 4'd6,
    FS_DCBLK = 4'd7,
    FS_MAVG  = 4'd8,
    FS_OSC   = 4'd9,
    FS_PROG  = 4'd15
  } fsel_e;

  typedef struct packed {
    logic signed [COEF_W-1:0] f0;
    logic signed [COEF_W-1:0] f1;
    logic signed [COEF_W-1:0] f2;
    logic signed [COEF_W-1:0] g1;
    logic signed [COEF_W-1:0] g2;
    logic                     diff_on;
    logic                     diff_long;
  } filt_cfg_t;

endpackage

// File: rtl/rfs_cfg_select.sv
module rfs_cfg_select
  import rfs_pkg::*;
#(
  parameter int SHORT_DLY = 8,
  parameter int OSC_G1    = 121095,
  parameter int LEAK_G1   = 61440
) (
  input  logic [3:0]               fsel,
  input  logic signed [COEF_W-1:0] prog_f0,
  input  logic signed [COEF_W-1:0] prog_f1,
  input  logic signed [COEF_W-1:0] prog_f2,
  input  logic signed [COEF_W-1:0] prog_g1,
  input  logic signed [COEF_W-1:0] prog_g2,
  input  logic                     prog_diff_on,
  input  logic                     prog_diff_long,
  output filt_cfg_t                cfg
);

  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1 << COEF_FRAC);
  localparam logic signed [COEF_W-1:0] MINUS = -UNITY;
  localparam logic signed [COEF_W-1:0] AVG_F0 = COEF_W'((1 << COEF_FRAC) / SHORT_DLY);
  localparam logic signed [COEF_W-1:0] LEAK = COEF_W'(LEAK_G1);
  localparam logic signed [COEF_W-1:0] OSC = COEF_W'(OSC_G1);

  always_comb begin
    cfg = '0;
    case (fsel_e'(fsel))
      FS_PASS:  cfg.f0 = UNITY;
      FS_DIFF: begin
        cfg.f0 = UNITY;
        cfg.f1 = MINUS;
      end
      FS_INTEG: begin
        cfg.f0 = UNITY;
        cfg.g1 = UNITY;
      end
      FS_LEAKY: begin
        cfg.f0 = UNITY;
        cfg.g1 = LEAK;
      end
      FS_COMB: begin
        cfg.f0      = UNITY;
        cfg.diff_on = 1'b1;
      end
      FS_BAND: begin
        cfg.f0        = UNITY;
        cfg.g2        = MINUS;
        cfg.diff_on   = 1'b1;
        cfg.diff_long = 1'b1;
      end
      FS_CIC: begin
        cfg.f0      = UNITY;
        cfg.g1      = UNITY;
        cfg.diff_on = 1'b1;
      end
      FS_DCBLK: begin
        cfg.f0 = UNITY;
        cfg.f1 = MINUS;
        cfg.g1 = LEAK;
      end
      FS_MAVG: begin
        cfg.f0      = AVG_F0;
        cfg.g1      = UNITY;
        cfg.diff_on = 1'b1;
      end
      FS_OSC: begin
        cfg.f0 = UNITY;
        cfg.g1 = OSC;
        cfg.g2 = MINUS;
      end
      FS_PROG: begin
        cfg.f0        = prog_f0;
        cfg.f1        = prog_f1;
        cfg.f2        = prog_f2;
        cfg.g1        = prog_g1;
        cfg.g2        = prog_g2;
        cfg.diff_on   = prog_diff_on;
        cfg.diff_long = prog_diff_long;
      end
      default:  cfg = '0;
    endcase
  end

endmodule

// File: rtl/rfs_diff_line.sv
module rfs_diff_line #(
  parameter int SW        = 16,
  parameter int SHORT_DLY = 8,
  parameter int LONG_DLY  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 shift,
  input  logic                 diff_on,
  input  logic                 diff_long,
  input  logic signed [SW-1:0] x,
  output logic signed [SW:0]   w
);

  localparam int WW = SW + 1;

  logic signed [SW-1:0] dl [LONG_DLY];
  logic signed [SW-1:0] old_x;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < LONG_DLY; i++) dl[i] <= '0;
    end else if (shift) begin
      dl[0] <= x;
      for (int i = 1; i < LONG_DLY; i++) dl[i] <= dl[i-1];
    end
  end

  generate
    if (SHORT_DLY == LONG_DLY) begin : g_one_len
      assign old_x = dl[LONG_DLY-1];
    end else begin : g_two_len
      assign old_x = diff_long ? dl[LONG_DLY-1] : dl[SHORT_DLY-1];
    end
  endgenerate

  always_comb begin
    if (diff_on) w = WW'(x) - WW'(old_x);
    else         w = WW'(x);
  end

endmodule

// File: rtl/rfs_section.sv
module rfs_section #(
  parameter int SW    = 16,
  parameter int CW    = 18,
  parameter int CFRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [SW:0]   w_in,
  input  logic signed [CW-1:0] f0,
  input  logic signed [CW-1:0] f1,
  input  logic signed [CW-1:0] f2,
  input  logic signed [CW-1:0] g1,
  input  logic signed [CW-1:0] g2,
  output logic                 y_valid,
  output logic signed [SW-1:0] y_out,
  output logic signed [SW-1:0] hist_y1,
  output logic signed [SW-1:0] hist_y2
);

  localparam int WW = SW + 1;
  localparam int NT = 5;
  localparam int AW = WW + CW + 3;
  localparam int QW = AW - CFRAC;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CFRAC - 1);
  localparam logic signed [QW-1:0] QMAX = QW'((1 << (SW - 1)) - 1);
  localparam logic signed [QW-1:0] QMIN = -QMAX - QW'(1);
  localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  function automatic logic signed [SW-1:0] round_sat(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] r;
    logic signed [QW-1:0] q;
    r = a + HALF;
    q = QW'(r >>> CFRAC);
    if (q > QMAX)      return SMAX;
    else if (q < QMIN) return SMIN;
    else               return SW'(q);
  endfunction

  logic signed [WW-1:0] w1, w2;
  logic signed [SW-1:0] y1, y2;
  logic signed [WW-1:0] tap_d [NT];
  logic signed [CW-1:0] tap_c [NT];
  logic signed [AW-1:0] prod  [NT];
  logic signed [AW-1:0] acc;
  logic signed [SW-1:0] y_new;

  assign tap_d[0] = w_in;
  assign tap_d[1] = w1;
  assign tap_d[2] = w2;
  assign tap_d[3] = {y1[SW-1], y1};
  assign tap_d[4] = {y2[SW-1], y2};
  assign tap_c[0] = f0;
  assign tap_c[1] = f1;
  assign tap_c[2] = f2;
  assign tap_c[3] = g1;
  assign tap_c[4] = g2;

  generate
    for (genvar i = 0; i < NT; i++) begin : g_mul
      assign prod[i] = AW'(tap_d[i]) * AW'(tap_c[i]);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < NT; i++) acc = acc + prod[i];
  end

  assign y_new = round_sat(acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      w1      <= '0;
      w2      <= '0;
      y1      <= '0;
      y2      <= '0;
      y_out   <= '0;
      y_valid <= 1'b0;
    end else if (clr) begin
      w1      <= '0;
      w2      <= '0;
      y1      <= '0;
      y2      <= '0;
      y_valid <= 1'b0;
    end else begin
      y_valid <= en;
      if (en) begin
        w1    <= w_in;
        w2    <= w1;
        y1    <= y_new;
        y2    <= y1;
        y_out <= y_new;
      end
    end
  end

  assign hist_y1 = y1;
  assign hist_y2 = y2;

endmodule

// File: rtl/recon_filter_section.sv
module recon_filter_section
  import rfs_pkg::*;
#(
  parameter int SHORT_DLY = 8,
  parameter int LONG_DLY  = 16,
  parameter int OSC_G1    = 121095,
  parameter int LEAK_G1   = 61440
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic [3:0]                 fsel,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_data,
  input  logic signed [COEF_W-1:0]   prog_f0,
  input  logic signed [COEF_W-1:0]   prog_f1,
  input  logic signed [COEF_W-1:0]   prog_f2,
  input  logic signed [COEF_W-1:0]   prog_g1,
  input  logic signed [COEF_W-1:0]   prog_g2,
  input  logic                       prog_diff_on,
  input  logic                       prog_diff_long,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_data
);

  localparam int WW = SAMPLE_W + 1;

  logic [3:0]                 sel_q;
  filt_cfg_t                  cfg_next, cfg_q;
  logic                       clr_evt;
  logic                       accept;
  logic                       stg_valid;
  logic                       sec_en;
  logic signed [WW-1:0]       w_comb, w_q;
  logic signed [SAMPLE_W-1:0] hist_y1, hist_y2;

  assign clr_evt = flush || (fsel != sel_q);
  assign accept  = in_valid && !clr_evt && !rst;
  assign sec_en  = stg_valid && !clr_evt;

  rfs_cfg_select #(
    .SHORT_DLY(SHORT_DLY),
    .OSC_G1   (OSC_G1),
    .LEAK_G1  (LEAK_G1)
  ) u_cfg (
    .fsel          (fsel),
    .prog_f0       (prog_f0),
    .prog_f1       (prog_f1),
    .prog_f2       (prog_f2),
    .prog_g1       (prog_g1),
    .prog_g2       (prog_g2),
    .prog_diff_on  (prog_diff_on),
    .prog_diff_long(prog_diff_long),
    .cfg           (cfg_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cfg_q <= '0;
    end else begin
      sel_q <= fsel;
      cfg_q <= cfg_next;
    end
  end

  rfs_diff_line #(
    .SW       (SAMPLE_W),
    .SHORT_DLY(SHORT_DLY),
    .LONG_DLY (LONG_DLY)
  ) u_diff (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_evt),
    .shift    (accept),
    .diff_on  (cfg_q.diff_on),
    .diff_long(cfg_q.diff_long),
    .x        (in_data),
    .w        (w_comb)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_evt) begin
      stg_valid <= 1'b0;
      w_q       <= '0;
    end else begin
      stg_valid <= accept;
      if (accept) w_q <= w_comb;
    end
  end

  rfs_section #(
    .SW   (SAMPLE_W),
    .CW   (COEF_W),
    .CFRAC(COEF_FRAC)
  ) u_sec (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_evt),
    .en     (sec_en),
    .w_in   (w_q),
    .f0     (cfg_q.f0),
    .f1     (cfg_q.f1),
    .f2     (cfg_q.f2),
    .g1     (cfg_q.g1),
    .g2     (cfg_q.g2),
    .y_valid(out_valid),
    .y_out  (out_data),
    .hist_y1(hist_y1),
    .hist_y2(hist_y2)
  );

endmodule

// File: rtl/rfs_filter_chk.sv
module rfs_filter_chk #(
  parameter int SW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr_evt,
  input logic                 accept,
  input logic                 out_valid,
  input logic signed [SW-1:0] out_data,
  input logic signed [SW-1:0] hist_y1,
  input logic signed [SW-1:0] hist_y2
);

  // R7: every output traces back to a sample accepted two edges before
  a_r7_origin: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(accept, 2));

  // R7: an accepted sample not cancelled by a clear is delivered
  a_r7_delivery: assert property (@(posedge clk) disable iff (rst)
    (accept ##1 !clr_evt) |=> out_valid);

  // R8: a clear empties the feedback history and cancels the output
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> (!out_valid && hist_y1 == '0 && hist_y2 == '0));

  // R8: the output sample holds between results
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R12: reset leaves no valid output and a zero sample
  a_r12_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

endmodule

bind recon_filter_section rfs_filter_chk #(.SW(rfs_pkg::SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_evt  (clr_evt),
  .accept   (accept),
  .out_valid(out_valid),
  .out_data (out_data),
  .hist_y1  (hist_y1),
  .hist_y2  (hist_y2)
);

// File: tb/recon_filter_section_tb.sv
`timescale 1ns/1ps
module recon_filter_section_tb;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               flush = 1'b0;
  logic [3:0]         fsel = 4'd0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic signed [17:0] prog_f0 = '0, prog_f1 = '0, prog_f2 = '0;
  logic signed [17:0] prog_g1 = '0, prog_g2 = '0;
  logic               prog_diff_on = 1'b0, prog_diff_long = 1'b0;
  logic               out_valid;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  recon_filter_section u_dut (
    .clk(clk), .rst(rst), .flush(flush), .fsel(fsel),
    .in_valid(in_valid), .in_data(in_data),
    .prog_f0(prog_f0), .prog_f1(prog_f1), .prog_f2(prog_f2),
    .prog_g1(prog_g1), .prog_g2(prog_g2),
    .prog_diff_on(prog_diff_on), .prog_diff_long(prog_diff_long),
    .out_valid(out_valid), .out_data(out_data)
  );

  // vector: {code[35:32], input[31:16], expected[15:0]}
  localparam int NV = 39;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0,  16'sd1234,   16'sd1234},
    {4'd0,  -16'sd5,     -16'sd5},
    {4'd1,  16'sd100,    16'sd100},
    {4'd1,  16'sd300,    16'sd200},
    {4'd1,  16'sd250,    -16'sd50},
    {4'd2,  16'sd100,    16'sd100},
    {4'd2,  16'sd300,    16'sd400},
    {4'd2,  16'sd250,    16'sd650},
    {4'd11, 16'sd1000,   16'sd0},
    {4'd2,  16'sd30000,  16'sd30000},
    {4'd2,  16'sd30000,  16'sd32767},
    {4'd2,  -16'sd1,     16'sd32766},
    {4'd3,  16'sd1600,   16'sd1600},
    {4'd3,  16'sd0,      16'sd1500},
    {4'd2,  -16'sd30000, -16'sd30000},
    {4'd2,  -16'sd30000, -16'sd32768},
    {4'd7,  16'sd160,    16'sd160},
    {4'd7,  16'sd160,    16'sd150},
    {4'd4,  16'sd7,      16'sd7},
    {4'd4,  16'sd0,      16'sd0},
    {4'd4,  16'sd0,      16'sd0},
    {4'd4,  16'sd0,      16'sd0},
    {4'd4,  16'sd0,      16'sd0},
    {4'd4,  16'sd0,      16'sd0},
    {4'd4,  16'sd0,      16'sd0},
    {4'd4,  16'sd0,      16'sd0},
    {4'd4,  16'sd3,      -16'sd4},
    {4'd5,  16'sd10,     16'sd10},
    {4'd5,  16'sd0,      16'sd0},
    {4'd5,  16'sd0,      -16'sd10},
    {4'd5,  16'sd0,      16'sd0},
    {4'd5,  16'sd0,      16'sd10},
    {4'd8,  16'sd800,    16'sd100},
    {4'd8,  16'sd800,    16'sd200},
    {4'd8,  16'sd0,      16'sd200},
    {4'd8,  16'sd4,      16'sd201},
    {4'd9,  16'sd1000,   16'sd1000},
    {4'd9,  16'sd0,      16'sd1848},
    {4'd9,  16'sd0,      16'sd2415}
  };

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd0:          return "R1";
      4'd1, 4'd2:    return "R3/R11";
      4'd3, 4'd7:    return "R4";
      4'd4, 4'd5:    return "R5";
      4'd6, 4'd8:    return "R6";
      4'd9:          return "R9";
      default:       return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic set_code(input logic [3:0] code);
    @(negedge clk);
    fsel = code;
    @(negedge clk);
  endtask

  task automatic send(input logic signed [15:0] x, output logic v,
                      output logic signed [15:0] y);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    v = out_valid;
    y = out_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic v;
    logic signed [15:0] y;

    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 valid", int'(out_valid), 0);
    chk("R12 data", int'(out_data), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 valid after release", int'(out_valid), 0);

    // table walk over the fixed codes
    for (int i = 0; i < NV; i++) begin
      logic [3:0]         code;
      logic signed [15:0] xi, ex;
      code = VEC[i][35:32];
      xi   = VEC[i][31:16];
      ex   = VEC[i][15:0];
      if (code != fsel) set_code(code);
      send(xi, v, y);
      chk({req_of(code), " valid"}, int'(v), 1);
      chk(req_of(code), int'(y), int'(ex));
    end

    // R8: flush clears integrator history
    set_code(4'd2);
    send(16'sd100, v, y);
    chk("R8 pre-flush", int'(y), 100);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    send(16'sd50, v, y);
    chk("R8 after flush", int'(y), 50);

    // R8: a sample offered on the code-change cycle is dropped
    @(negedge clk);
    fsel     = 4'd1;
    in_valid = 1'b1;
    in_data  = 16'sd999;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 dropped valid", int'(out_valid), 0);
    @(negedge clk);
    chk("R8 dropped valid 2", int'(out_valid), 0);
    chk("R8 data held", int'(out_data), 50);
    send(16'sd7, v, y);
    chk("R8 no leak of dropped sample", int'(y), 7);

    // R6/R7: back-to-back stream through the comb-integrator interpolator
    set_code(4'd6);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      if (i >= 2 && i < 12) begin
        chk("R7 stream valid", int'(out_valid), 1);
        chk("R6 stream data", int'(out_data), (i - 2) < 8 ? 5 * (i - 1) : 40);
      end
      if (i == 12) chk("R7 one output per sample", int'(out_valid), 0);
      in_valid = (i < 10);
      in_data  = 16'sd5;
    end
    in_valid = 1'b0;

    // R2/R10: programmable code with the long differencer delay
    @(negedge clk);
    prog_f0        = 18'sd65536;
    prog_f1        = '0;
    prog_diff_on   = 1'b1;
    prog_diff_long = 1'b1;
    set_code(4'd15);
    for (int i = 0; i < 17; i++) begin
      send(i == 0 ? 16'sd3 : 16'sd0, v, y);
      if (i == 0)  chk("R2 first", int'(y), 3);
      if (i == 8)  chk("R2 no short-delay tap", int'(y), 0);
      if (i == 16) chk("R2 long delay", int'(y), -3);
    end

    // R10: programmable feedforward pair, differencer off
    @(negedge clk);
    prog_f0      = 18'sd32768;
    prog_f1      = 18'sd32768;
    prog_diff_on = 1'b0;
    flush        = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
    send(16'sd100, v, y);
    chk("R10 prog first", int'(y), 50);
    send(16'sd300, v, y);
    chk("R10 prog second", int'(y), 200);

    finish_run();
  end

endmodule